// File: doc/BRIEF.md
# Dual-Issue Pairing Decision Unit

This block decides, every clock cycle, how many instructions an in-order dual pipeline starts. It looks at the two oldest decoded instructions in program order. The older one always goes to the main pipe, which can run any instruction. The younger one may go to a restricted secondary pipe in the same cycle, but only when the pair is safe to run side by side.

Pairing needs all of the following: the younger instruction is valid, both instructions are marked simple, the older one is not a branch, and there is no register conflict between the two. A conflict is either the younger instruction reading the register that the older one writes, or both instructions writing the same register. When any of these conditions fails, only the older instruction issues. The younger one then stays in the queue and becomes the older slot of the next decision. A stall input holds both pipes idle.

The decision is registered. The issue enables and the consume count seen at the outputs belong to the inputs that were present at the previous rising clock edge. The consume count tells the instruction queue how many entries to retire.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are cleared after that edge: both issue enables are 0 and `take` is 0.
- R2: When `stall` is high, neither pipe issues and `take` is 0, whatever the instruction fields hold.
- R3: When the older slot is not valid, neither pipe issues and `take` is 0.
- R4: When the older slot is valid and `stall` is low, `issue_main` is 1.
- R5: The secondary pipe issues only when both instructions are flagged simple.
- R6: The secondary pipe never issues when the older instruction is a branch.
- R7: The secondary pipe never issues when the older instruction has a valid destination equal to either valid source of the younger instruction (read-after-write).
- R8: The secondary pipe never issues when both destinations are valid and equal (write-after-write).
- R9: The secondary pipe never issues when the younger slot is not valid.
- R10: A destination whose valid bit is low causes no conflict, and a younger source whose valid bit is low is never compared. When every other condition holds, the pair issues.
- R11: `take` is encoded as 0 for no issue, 1 for the older only and 2 for a pair. The value 3 never appears.
- R12: The outputs are registered. A change at the inputs shows at the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds both pipes idle this cycle |
| old_valid | input | 1 | Older slot holds an instruction |
| old_simple | input | 1 | Older instruction may run in the secondary pipe |
| old_branch | input | 1 | Older instruction changes control flow |
| old_dst_vld | input | 1 | Older instruction writes a register |
| old_dst | input | RW | Destination register index of the older instruction |
| yng_valid | input | 1 | Younger slot holds an instruction |
| yng_simple | input | 1 | Younger instruction may run in the secondary pipe |
| yng_dst_vld | input | 1 | Younger instruction writes a register |
| yng_dst | input | RW | Destination register index of the younger instruction |
| yng_src_vld | input | NSRC | Per-source valid bits of the younger instruction |
| yng_src | input | NSRC*RW | Packed source indices of the younger instruction, source 0 in the low bits |
| issue_main | output | 1 | Older instruction starts in the main pipe |
| issue_sec | output | 1 | Younger instruction starts in the secondary pipe |
| take | output | 2 | Number of queue entries consumed (0, 1 or 2) |

## Verification
Several blocking causes can hit the same pair in one cycle. The most telling case is a read-after-write and a write-after-write together, where the younger instruction reads and writes the register the older one writes. The bench reaches this by sweeping every combination of valid bits and indices on a narrow register field. The same sweep also lays a stall over a pair that could otherwise issue. In each case the expected outcome is worked out from the rules alone: the older instruction issues on its own (or nothing issues under stall), and `take` matches the number of pipes that start.

// File: rtl/dip_pkg.sv
package dip_pkg;

  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_ONE  = 2'd1,
    TAKE_TWO  = 2'd2
  } take_e;

  typedef struct packed {
    logic  main;
    logic  sec;
    take_e take;
  } issue_t;

  localparam issue_t ISSUE_IDLE = '{main: 1'b0, sec: 1'b0, take: TAKE_NONE};

endpackage

// File: rtl/dip_hazard.sv
module dip_hazard #(
  parameter int RW   = 5,
  parameter int NSRC = 2
) (
  input  logic                 old_dst_vld,
  input  logic [RW-1:0]        old_dst,
  input  logic                 yng_dst_vld,
  input  logic [RW-1:0]        yng_dst,
  input  logic [NSRC-1:0]      yng_src_vld,
  input  logic [NSRC*RW-1:0]   yng_src,
  output logic                 raw,
  output logic                 waw
);

  logic [NSRC-1:0] src_hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit[s] = yng_src_vld[s] && (yng_src[s*RW +: RW] == old_dst);
  end

  assign raw = old_dst_vld && (|src_hit);
  assign waw = old_dst_vld && yng_dst_vld && (old_dst == yng_dst);

  // R10: with no older destination, no hazard may be reported
  always_comb begin
    if (!old_dst_vld) begin
      p_nodst_noconf_r10: assert (!raw && !waw);
    end
  end

endmodule

// File: rtl/dip_decide.sv
module dip_decide
  import dip_pkg::*;
(
  input  logic   stall,
  input  logic   old_valid,
  input  logic   old_simple,
  input  logic   old_branch,
  input  logic   yng_valid,
  input  logic   yng_simple,
  input  logic   raw,
  input  logic   waw,
  output issue_t dec
);

  logic can_go;
  logic can_pair;

  assign can_go   = old_valid && !stall;
  assign can_pair = yng_valid && old_simple && yng_simple && !old_branch && !raw && !waw;

  always_comb begin
    dec = ISSUE_IDLE;
    if (can_go) begin
      dec.main = 1'b1;
      dec.take = TAKE_ONE;
      if (can_pair) begin
        dec.sec  = 1'b1;
        dec.take = TAKE_TWO;
      end
    end
  end

  // R11: the secondary pipe never runs without the main pipe
  always_comb begin
    if (dec.sec) begin
      p_sec_with_main_r11: assert (dec.main && dec.take == TAKE_TWO);
    end
  end

endmodule

// File: rtl/dip_issue_reg.sv
module dip_issue_reg
  import dip_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  issue_t d,
  output issue_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= ISSUE_IDLE;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter int RW   = 5,
  parameter int NSRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic               old_valid,
  input  logic               old_simple,
  input  logic               old_branch,
  input  logic               old_dst_vld,
  input  logic [RW-1:0]      old_dst,
  input  logic               yng_valid,
  input  logic               yng_simple,
  input  logic               yng_dst_vld,
  input  logic [RW-1:0]      yng_dst,
  input  logic [NSRC-1:0]    yng_src_vld,
  input  logic [NSRC*RW-1:0] yng_src,
  output logic               issue_main,
  output logic               issue_sec,
  output logic [1:0]         take
);

  logic   raw;
  logic   waw;
  issue_t dec;
  issue_t dec_q;

  dip_hazard #(.RW(RW), .NSRC(NSRC)) u_hazard (
    .old_dst_vld (old_dst_vld),
    .old_dst     (old_dst),
    .yng_dst_vld (yng_dst_vld),
    .yng_dst     (yng_dst),
    .yng_src_vld (yng_src_vld),
    .yng_src     (yng_src),
    .raw         (raw),
    .waw         (waw)
  );

  dip_decide u_decide (
    .stall      (stall),
    .old_valid  (old_valid),
    .old_simple (old_simple),
    .old_branch (old_branch),
    .yng_valid  (yng_valid),
    .yng_simple (yng_simple),
    .raw        (raw),
    .waw        (waw),
    .dec        (dec)
  );

  dip_issue_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (dec),
    .q   (dec_q)
  );

  assign issue_main = dec_q.main;
  assign issue_sec  = dec_q.sec;
  assign take       = dec_q.take;

  p_stall_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $past(stall) |-> (!issue_main && !issue_sec && take == 2'd0));

  p_old_invalid_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(old_valid) |-> (!issue_main && !issue_sec));

  p_main_issues_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(old_valid) && !$past(stall)) |-> issue_main);

  p_simple_only_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(old_simple) || !$past(yng_simple)) |-> !issue_sec);

  p_branch_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    $past(old_branch) |-> !issue_sec);

  p_raw_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    $past(raw) |-> !issue_sec);

  p_waw_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    $past(waw) |-> !issue_sec);

  p_yng_invalid_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(yng_valid) |-> !issue_sec);

  p_take_legal_r11: assert property (@(posedge clk) disable iff (rst)
    (take != 2'd3) && (take == 2'(issue_main) + 2'(issue_sec)));

endmodule

// File: tb/dual_issue_pair_tb.sv
module dual_issue_pair_tb;

  localparam int RW   = 2;
  localparam int NSRC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0;
  logic old_valid = 1'b0, old_simple = 1'b0, old_branch = 1'b0, old_dst_vld = 1'b0;
  logic [RW-1:0] old_dst = '0;
  logic yng_valid = 1'b0, yng_simple = 1'b0, yng_dst_vld = 1'b0;
  logic [RW-1:0] yng_dst = '0;
  logic [NSRC-1:0] yng_src_vld = '0;
  logic [NSRC*RW-1:0] yng_src = '0;
  logic issue_main, issue_sec;
  logic [1:0] take;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_issue_pair #(.RW(RW), .NSRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .stall(stall),
    .old_valid(old_valid), .old_simple(old_simple), .old_branch(old_branch),
    .old_dst_vld(old_dst_vld), .old_dst(old_dst),
    .yng_valid(yng_valid), .yng_simple(yng_simple),
    .yng_dst_vld(yng_dst_vld), .yng_dst(yng_dst),
    .yng_src_vld(yng_src_vld), .yng_src(yng_src),
    .issue_main(issue_main), .issue_sec(issue_sec), .take(take)
  );

  task automatic check3(string tag, logic em, logic es, logic [1:0] et);
    checks++;
    if (issue_main !== em || issue_sec !== es || take !== et) begin
      errors++;
      $display("FAIL %s: got main=%b sec=%b take=%0d, expected main=%b sec=%b take=%0d",
               tag, issue_main, issue_sec, take, em, es, et);
    end
  endtask

  // Model of the rules; returns the requirement that decides the outcome
  task automatic expect_now(output logic em, output logic es, output logic [1:0] et,
                            output string tag);
    logic raw, waw;
    raw = old_dst_vld && ((yng_src_vld[0] && yng_src[RW-1:0] == old_dst) ||
                          (yng_src_vld[1] && yng_src[2*RW-1:RW] == old_dst));
    waw = old_dst_vld && yng_dst_vld && (old_dst == yng_dst);
    em = 1'b0; es = 1'b0; et = 2'd0;
    if (stall)                          tag = "R2";
    else if (!old_valid)                tag = "R3";
    else begin
      em = 1'b1; et = 2'd1;
      if (!yng_valid)                   tag = "R9";
      else if (!old_simple || !yng_simple) tag = "R5";
      else if (old_branch)              tag = "R6";
      else if (raw)                     tag = "R7";
      else if (waw)                     tag = "R8";
      else begin es = 1'b1; et = 2'd2; tag = "R10"; end
    end
  endtask

  // Drive at a falling edge, judge after the next rising edge (R12 latency)
  task automatic step_and_check();
    logic em, es;
    logic [1:0] et;
    string tag;
    expect_now(em, es, et, tag);
    @(negedge clk);
    check3(tag, em, es, et);
    if (em) check3("R4", em, es, et);
    if (em) check3("R11", em, es, et);
  endtask

  initial begin
    #(10 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got running, expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset clears outputs even with a pairable pair at the inputs
    old_valid = 1; old_simple = 1; yng_valid = 1; yng_simple = 1;
    repeat (3) @(negedge clk);
    check3("R1", 1'b0, 1'b0, 2'd0);
    rst = 0;
    step_and_check();

    // R12: inputs changed at a falling edge do not reach the outputs before the rising edge
    stall = 1;
    @(negedge clk);
    stall = 0;
    #2;
    check3("R12", 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    check3("R12", 1'b1, 1'b1, 2'd2);

    // Full sweep of register fields on an otherwise pairable pair (R7, R8, R10)
    old_valid = 1; old_simple = 1; old_branch = 0; yng_valid = 1; yng_simple = 1; stall = 0;
    for (int v = 0; v < 4096; v++) begin
      logic [11:0] b;
      b = 12'(v);
      old_dst_vld = b[0]; old_dst = b[2:1];
      yng_dst_vld = b[3]; yng_dst = b[5:4];
      yng_src_vld = b[7:6]; yng_src = b[11:8];
      step_and_check();
    end

    // Control sweep crossed with register patterns: clean, RAW on each source, WAW, RAW+WAW
    for (int p = 0; p < 5; p++) begin
      for (int c = 0; c < 64; c++) begin
        logic [5:0] k;
        k = 6'(c);
        {stall, old_valid, old_simple, old_branch, yng_valid, yng_simple} = k;
        old_dst_vld = 1; old_dst = 2'd1;
        yng_dst_vld = 1; yng_dst = 2'd2;
        yng_src_vld = 2'b11; yng_src = {2'd3, 2'd0};
        case (p)
          1: yng_src = {2'd3, 2'd1};
          2: yng_src = {2'd1, 2'd0};
          3: yng_dst = 2'd1;
          4: begin yng_dst = 2'd1; yng_src = {2'd3, 2'd1}; end
          default: ;
        endcase
        step_and_check();
      end
    end

    // R1 again: reset in mid-run clears a live pair
    old_valid = 1; old_simple = 1; old_branch = 0; yng_valid = 1; yng_simple = 1;
    old_dst_vld = 0; yng_dst_vld = 0; yng_src_vld = 0; stall = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check3("R1", 1'b0, 1'b0, 2'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule